// File: doc/BRIEF.md
# Interrupt Cause and Mask Controller

This block gathers up to 29 level-sensitive peripheral event lines into one CPU interrupt. Each source owns one bit, at positions 1 to 29, of a 32-bit cause register. An event sets its bit, and the bit stays set until software clears it. A 32-bit mask register chooses which pending causes may raise the interrupt line. The block also reports the lowest-numbered pending source that is enabled, with a flag that says whether that index is valid.

Software reaches both registers through a single-cycle register port. One select bit picks the cause register or the mask register. A write takes effect at the clock edge. A read returns data combinationally from the registered state. To clear a cause bit, software writes 0 to that bit and 1 to every other bit, so a read-modify-write touches only the target.

Three positions of the cause word are summary flags that software can only read:
- Bit 0 is the OR of all 29 sources.
- Bit 30 is the OR of sources 1 to 20 and 26 to 29.
- Bit 31 is the OR of sources 1 to 25.

Top module: `irq_cause_mask_ctrl`

## Requirements
- R1: After the asynchronous reset, both registers read as zero, and `irq_o` and `pend_valid_o` are low.
- R2: When source input `evt_i[k]` (k from 1 to 29) is high at a clock edge, cause bit k reads as 1 after that edge. The bit stays 1 after the input returns low.
- R3: A write to the cause register (`reg_sel_i`=0) with data bit k at 0 clears cause bit k. A data bit at 1 leaves the matching cause bit unchanged.
- R4: If `evt_i[k]` is high in the same cycle that software writes 0 to cause bit k, the bit stays set. A level that is still held therefore re-sets the bit.
- R5: `irq_o` is high exactly when some source k in 1 to 29 has both its cause bit and its mask bit at 1. A mask bit at 0 blocks the interrupt for that source, but the cause bit still records the event.
- R6: `pend_valid_o` is high when `irq_o` is high. `pend_idx_o` then gives the lowest k whose cause bit and mask bit are both 1.
- R7: Cause read bit 0 equals the OR of cause bits 1 to 29.
- R8: Cause read bit 30 equals the OR of cause bits 26 to 29 and 1 to 20. Bits 21 to 25 do not contribute.
- R9: Cause read bit 31 equals the OR of cause bits 1 to 25.
- R10: Writes to cause bits 0, 30 and 31 have no effect. Those bits always show the summary values.
- R11: The mask register stores and reads back all 32 bits. Mask bits 0, 30 and 31 do not gate any source.
- R12: Register writes happen only on a clock edge where `reg_we_i` is high. `reg_sel_i`=1 selects the mask register and `reg_sel_i`=0 selects the cause register. `reg_rdata_o` shows the selected register combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 29 | Source event levels, indexed 29 down to 1 |
| reg_sel_i | input | 1 | Register select: 0 cause, 1 mask |
| reg_we_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data of the selected register |
| irq_o | output | 1 | CPU interrupt line |
| pend_valid_o | output | 1 | An enabled cause is pending |
| pend_idx_o | output | 5 | Lowest enabled pending source index |

## Verification
The assertions take for granted that `evt_i` and the register port inputs are stable around each rising edge. They also assume that an event on a source with no clearing write in that cycle must be seen in the next cycle. The bench changes every input only on the falling edge and samples outputs one falling edge after the stimulus edge. Each write strobe is held for exactly one cycle and then dropped. Event pulses last one cycle, except the held levels used to test the set-versus-clear race.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  parameter int unsigned REG_W  = 32;
  parameter int unsigned SRC_LO = 1;
  parameter int unsigned SRC_HI = 29;
  parameter int unsigned IDX_W  = $clog2(REG_W);

  // summary bit positions
  parameter int unsigned SUM_ALL = 0;
  parameter int unsigned SUM_A   = 30;
  parameter int unsigned SUM_B   = 31;

  function automatic logic [REG_W-1:0] span(int unsigned lo, int unsigned hi);
    logic [REG_W-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < REG_W; i++)
      if (i >= lo && i <= hi) m[i] = 1'b1;
    return m;
  endfunction

  parameter logic [REG_W-1:0] SRC_SPAN = span(SRC_LO, SRC_HI);
  parameter logic [REG_W-1:0] GRP_A    = span(26, 29) | span(1, 20);
  parameter logic [REG_W-1:0] GRP_B    = span(1, 25);
endpackage

// File: rtl/irq_cause_bank.sv
module irq_cause_bank
  import irq_agg_pkg::*;
#(
  parameter int unsigned LO = SRC_LO,
  parameter int unsigned HI = SRC_HI
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [HI:LO] evt_i,
  input  logic         clr_we_i,
  input  logic [HI:LO] keep_i,
  output logic [HI:LO] cause_o
);
  logic [HI:LO] cause_q;

  for (genvar k = LO; k <= HI; k++) begin : g_bit
    logic clr;
    assign clr = clr_we_i & ~keep_i[k];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        cause_q[k] <= 1'b0;
      else if (evt_i[k])  cause_q[k] <= 1'b1;  // event beats clear
      else if (clr)       cause_q[k] <= 1'b0;
    end
  end

  assign cause_o = cause_q;

  // R2
  evt_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((cause_o & $past(evt_i)) == $past(evt_i)));
  // R3
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_we_i |=> ((cause_o & $past(cause_o)) == $past(cause_o)));
  // R3
  keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_i |=> ((cause_o & $past(cause_o & keep_i)) == $past(cause_o & keep_i)));
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank
  import irq_agg_pkg::*;
#(
  parameter int unsigned W = REG_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_q <= '0;
    else if (we_i) mask_q <= wdata_i;
  end

  assign mask_o = mask_q;

  // R12
  mask_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(mask_o));
endmodule

// File: rtl/irq_first_set.sv
module irq_first_set
  import irq_agg_pkg::*;
#(
  parameter int unsigned W  = REG_W,
  parameter int unsigned IW = IDX_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [W-1:0]  req_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        valid_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end

  // R6
  first_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (req_i[idx_o] && ((req_i & ((W'(1) << idx_o) - W'(1))) == '0)));
endmodule

// File: rtl/irq_cause_mask_ctrl.sv
module irq_cause_mask_ctrl
  import irq_agg_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [SRC_HI:SRC_LO] evt_i,
  input  logic                 reg_sel_i,
  input  logic                 reg_we_i,
  input  logic [REG_W-1:0]     reg_wdata_i,
  output logic [REG_W-1:0]     reg_rdata_o,
  output logic                 irq_o,
  output logic                 pend_valid_o,
  output logic [IDX_W-1:0]     pend_idx_o
);
  logic [SRC_HI:SRC_LO] cause_bits;
  logic [REG_W-1:0]     src_w, mask_w, cause_view, req_w;

  irq_cause_bank #(.LO(SRC_LO), .HI(SRC_HI)) u_cause (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (evt_i),
    .clr_we_i (reg_we_i & ~reg_sel_i),
    .keep_i   (reg_wdata_i[SRC_HI:SRC_LO]),
    .cause_o  (cause_bits)
  );

  irq_mask_bank #(.W(REG_W)) u_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i & reg_sel_i),
    .wdata_i (reg_wdata_i),
    .mask_o  (mask_w)
  );

  assign src_w = REG_W'({cause_bits, {SRC_LO{1'b0}}});

  always_comb begin
    cause_view          = src_w;
    cause_view[SUM_ALL] = |(src_w & SRC_SPAN);
    cause_view[SUM_A]   = |(src_w & GRP_A);
    cause_view[SUM_B]   = |(src_w & GRP_B);
  end

  assign req_w = src_w & mask_w & SRC_SPAN;

  irq_first_set #(.W(REG_W), .IW(IDX_W)) u_pick (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_w),
    .valid_o (pend_valid_o),
    .idx_o   (pend_idx_o)
  );

  assign irq_o       = |req_w;
  assign reg_rdata_o = reg_sel_i ? mask_w : cause_view;

  // R5
  irq_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == pend_valid_o);
  // R7
  sum_union_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cause_view[SUM_ALL] == (cause_view[SUM_A] | cause_view[SUM_B]));
endmodule

// File: tb/sim_irq_cause_mask_ctrl.sv
`timescale 1ns/1ps
module sim_irq_cause_mask_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [29:1] evt_i = '0;
  logic        reg_sel_i = 1'b0, reg_we_i = 1'b0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        irq_o, pend_valid_o;
  logic [4:0]  pend_idx_o;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  irq_cause_mask_ctrl u0 (.*);

  localparam int NV = 8;
  localparam logic [31:0] V_EVT [NV] = '{32'h0000_0020, 32'h2000_0088, 32'h0000_0088,
    32'h0040_0000, 32'h0800_0000, 32'hC000_0001, 32'h2080_0000, 32'h0020_0002};
  localparam logic [31:0] V_MSK [NV] = '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0080,
    32'h0000_0000, 32'h0800_0000, 32'hFFFF_FFFF, 32'h2000_0000, 32'h3FFF_FFFE};
  localparam logic [4:0] V_IDX [NV] = '{5'd5, 5'd3, 5'd7, 5'd0, 5'd27, 5'd0, 5'd29, 5'd1};
  localparam logic V_IRQ [NV] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1};

  function automatic logic [31:0] exp_cause(logic [31:0] e);
    logic [31:0] s, r;
    s = e & 32'h3FFF_FFFE;
    r = s;
    r[0]  = |s[29:1];
    r[30] = (|s[29:26]) | (|s[20:1]);
    r[31] = |s[25:1];
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk_i);
  endtask

  task automatic wr(logic sel, logic [31:0] d);
    reg_sel_i = sel; reg_we_i = 1'b1; reg_wdata_i = d;
    cyc();
    reg_we_i = 1'b0;
  endtask

  task automatic rd(logic sel, output logic [31:0] d);
    reg_sel_i = sel; reg_we_i = 1'b0;
    #1 d = reg_rdata_o;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    cyc(); cyc();
    // R1 reset state
    rd(0, r); check("R1 cause", r, 0);
    rd(1, r); check("R1 mask", r, 0);
    check("R1 irq", {31'b0, irq_o}, 0);
    check("R1 valid", {31'b0, pend_valid_o}, 0);
    rst_ni = 1'b1;
    cyc();

    for (int i = 0; i < NV; i++) begin
      wr(0, 32'h0);
      wr(1, V_MSK[i]);
      evt_i = V_EVT[i][29:1];
      cyc();
      evt_i = '0;
      cyc();
      rd(0, r);
      check("R2 cause", r & 32'h3FFF_FFFE, exp_cause(V_EVT[i]) & 32'h3FFF_FFFE);
      check("R7 sum0", {31'b0, r[0]}, {31'b0, exp_cause(V_EVT[i])[0]});
      check("R8 sum30", {31'b0, r[30]}, {31'b0, exp_cause(V_EVT[i])[30]});
      check("R9 sum31", {31'b0, r[31]}, {31'b0, exp_cause(V_EVT[i])[31]});
      check("R5 irq", {31'b0, irq_o}, {31'b0, V_IRQ[i]});
      check("R6 valid", {31'b0, pend_valid_o}, {31'b0, V_IRQ[i]});
      if (V_IRQ[i]) check("R6 idx", {27'b0, pend_idx_o}, {27'b0, V_IDX[i]});
    end

    // R3 read-modify-write clears only the target
    wr(0, 32'h0); wr(1, 32'hFFFF_FFFF);
    evt_i = '0; evt_i[4] = 1'b1; evt_i[9] = 1'b1;
    cyc(); evt_i = '0;
    rd(0, r);
    wr(0, r & ~32'h10);
    rd(0, r); check("R3 rmw clear", r, exp_cause(32'h200));
    wr(0, 32'hFFFF_FFFF);
    rd(0, r); check("R3 ones keep", r, exp_cause(32'h200));

    // R4 held level beats the clear
    wr(0, 32'h0);
    evt_i[6] = 1'b1;
    cyc();
    wr(0, 32'h0);
    rd(0, r); check("R4 event wins", r, exp_cause(32'h40));
    evt_i = '0;
    wr(0, 32'h0);
    rd(0, r); check("R4 clear after drop", r, 0);

    // R11 mask storage of non-source bits, no gating
    wr(1, 32'hC000_0001);
    rd(1, r); check("R11 mask readback", r, 32'hC000_0001);
    evt_i[10] = 1'b1; cyc(); evt_i = '0;
    check("R11 irq gated", {31'b0, irq_o}, 0);
    check("R5 masked valid", {31'b0, pend_valid_o}, 0);
    rd(0, r); check("R5 masked recorded", r, exp_cause(32'h400));

    // R12 no write without strobe
    reg_sel_i = 1'b1; reg_we_i = 1'b0; reg_wdata_i = 32'hFFFF_FFFF;
    cyc();
    rd(1, r); check("R12 no strobe", r, 32'hC000_0001);

    // R10 writes to summary bits ignored
    wr(0, 32'h3FFF_FFFE);
    rd(0, r); check("R10 summary write", r, exp_cause(32'h400));
    wr(0, 32'h0);
    wr(0, 32'hC000_0001);
    rd(0, r); check("R10 summary set", r, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule